// File: doc/BRIEF.md
# Single-Frame Packet Buffer Host Interface

This block sits between a host processor bus and the line side of a small Ethernet-style controller. It holds one frame at a time in each direction and lets the host exchange it through a few 32-bit registers. A received frame is stored word by word. Once its last word lands, a control register reports that a frame is waiting, together with its byte length and two error flags. The host drains the words one read at a time from a data register and then writes zero to the control register. That write hands the buffer back to the line side.

To send, the host writes the frame words into a transmit data register. It then writes the transmit control register with the byte length and the start bit set. The block streams ceil(length/4) words to the line side. When the line side reports completion, the block clears the start bit and records the outcome. A single interrupt line combines a receive-ready cause and a transmit-finished cause, and each cause has its own enable bit.

Top module: `pktbuf_host_if`

## Requirements
- R1: The receive control word (address 0) reads as bit 15 = frame ready, bit 14 = general error, bit 13 = CRC error and bits 12:0 = byte length. Frame ready rises in the cycle after the line side pushes the word marked last, and the length and error flags are taken from that push.
- R2: While a frame is ready, each bus read of address 1 returns the next stored word in arrival order, oldest first, and consumes it.
- R3: A bus write of the value zero to address 0 clears frame ready, the flags and the length, and discards any words left in the buffer. A nonzero write to address 0 changes nothing.
- R4: A read of address 1 while no frame is ready returns zero and consumes no word.
- R5: `rx_push_ready` is low for as long as a frame is ready, and is high after reset.
- R6: A write to address 2 with bit 15 set starts a transmission of bits 12:0 bytes. The stored words are offered on the pop stream in write order, and `tx_pop_last` is high on word ceil(length/4).
- R7: A `tx_done_valid` pulse during a transmission clears the start bit. It sets the done bit (bit 13 of address 2), copies `tx_done_err` into the error bit (bit 14), and empties the transmit buffer.
- R8: Writes to the transmit data register (address 3) are ignored while the start bit is set.
- R9: The `irq` output equals (frame ready AND enable bit 0) OR (transmit done AND enable bit 1), with the enables at address 4. Writing zero there masks both causes.
- R10: A write to address 2 with bit 15 clear, while no transmission runs, clears the done and error bits.
- R11: After reset the control words and the enable register read zero and `irq` is low.
- R12: A frame pushed with an error or CRC flag is reported as ready with that flag, and its words are still drained through address 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe; a read of address 1 consumes a word |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the read strobe |
| rx_push_valid | input | 1 | Line side offers a receive word |
| rx_push_data | input | 32 | Receive word |
| rx_push_last | input | 1 | Marks the final word of a frame |
| rx_push_len | input | 11 | Frame byte length, sampled with the last word |
| rx_push_err | input | 1 | General error flag, sampled with the last word |
| rx_push_crc | input | 1 | CRC error flag, sampled with the last word |
| rx_push_ready | output | 1 | Receive buffer can take a word |
| tx_pop_valid | output | 1 | Transmit word offered to the line side |
| tx_pop_data | output | 32 | Transmit word |
| tx_pop_last | output | 1 | Final word of the transmission |
| tx_pop_ready | input | 1 | Line side takes the offered word |
| tx_done_valid | input | 1 | Line side reports the transmission finished |
| tx_done_err | input | 1 | The finished transmission failed |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the ports is a transmit data write that arrives while a transmission is running, because the transmitter stops after ceil(length/4) words and would hide a stray extra word. The stimulus therefore starts an 8-byte transmission with only one word stored and writes a second word after the start. A correct block then offers exactly one word and drops valid. A block that stored the late word offers it as the second word, and the bench catches that. Receive frames of 5, 8, 64 and 1518 bytes, with and without error flags, are taken from a table. The largest one fills the buffer to its full depth.

// File: rtl/pktbuf_pkg.sv
package pktbuf_pkg;

    localparam int BUS_DW    = 32;
    localparam int BUS_AW    = 3;
    localparam int LEN_FIELD = 13;

    typedef enum logic [BUS_AW-1:0] {
        SEL_RX_CTL  = 3'd0,
        SEL_RX_WORD = 3'd1,
        SEL_TX_CTL  = 3'd2,
        SEL_TX_WORD = 3'd3,
        SEL_IRQ_EN  = 3'd4
    } reg_sel_e;

    // Control word layout shared by both directions (low half of the bus word)
    typedef struct packed {
        logic                 own;   // rx: frame ready, tx: start
        logic                 err;   // rx: general error, tx: failure
        logic                 aux;   // rx: CRC error, tx: done
        logic [LEN_FIELD-1:0] len;
    } ctl_word_t;

    function automatic logic [BUS_DW-1:0] ctl_to_bus(input ctl_word_t c);
        return {{(BUS_DW-$bits(ctl_word_t)){1'b0}}, c};
    endfunction

endpackage

// File: rtl/pktbuf_word_fifo.sv
module pktbuf_word_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 380
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         rd,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;

    logic do_wr, do_rd;
    assign do_wr = wr && !full;
    assign do_rd = rd && !empty;
    assign empty = (cnt == '0);
    assign full  = (cnt == CW'(DEPTH));
    assign rdata = mem[rp];

    always_ff @(posedge clk) begin
        if (do_wr) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_wr) wp <= (wp == LAST) ? '0 : wp + 1'b1;
            if (do_rd) rp <= (rp == LAST) ? '0 : rp + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/pktbuf_rx_side.sv
module pktbuf_rx_side
    import pktbuf_pkg::*;
#(
    parameter int DEPTH = 380,
    parameter int LEN_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BUS_DW-1:0] in_data,
    input  logic              in_last,
    input  logic [LEN_W-1:0]  in_len,
    input  logic              in_err,
    input  logic              in_crc,
    output logic              in_ready,
    input  logic              host_pop,
    input  logic              host_ack,
    output logic [BUS_DW-1:0] word_out,
    output ctl_word_t         ctl_out
);
    logic             rdy_q, err_q, crc_q;
    logic [LEN_W-1:0] len_q;
    logic             f_empty, f_full;
    logic [BUS_DW-1:0] f_head;
    logic             accept, pop;

    assign in_ready = !rdy_q && !f_full;
    assign accept   = in_valid && in_ready;
    assign pop      = host_pop && rdy_q && !f_empty;

    pktbuf_word_fifo #(.W(BUS_DW), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .flush(host_ack && rdy_q),
        .wr(accept), .wdata(in_data),
        .rd(pop), .rdata(f_head),
        .empty(f_empty), .full(f_full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rdy_q <= 1'b0;
            err_q <= 1'b0;
            crc_q <= 1'b0;
            len_q <= '0;
        end else if (rdy_q) begin
            if (host_ack) begin
                rdy_q <= 1'b0;
                err_q <= 1'b0;
                crc_q <= 1'b0;
                len_q <= '0;
            end
        end else if (accept && in_last) begin
            rdy_q <= 1'b1;
            err_q <= in_err;
            crc_q <= in_crc;
            len_q <= in_len;
        end
    end

    assign word_out = (rdy_q && !f_empty) ? f_head : '0;

    always_comb begin
        ctl_out                = '0;
        ctl_out.own            = rdy_q;
        ctl_out.err            = err_q;
        ctl_out.aux            = crc_q;
        ctl_out.len[LEN_W-1:0] = len_q;
    end
endmodule

// File: rtl/pktbuf_tx_side.sv
module pktbuf_tx_side
    import pktbuf_pkg::*;
#(
    parameter int DEPTH = 380,
    parameter int LEN_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic [BUS_DW-1:0] host_wdata,
    input  logic              ctl_wr,
    input  logic              ctl_start,
    input  logic [LEN_W-1:0]  ctl_len,
    output logic              out_valid,
    output logic [BUS_DW-1:0] out_data,
    output logic              out_last,
    input  logic              out_ready,
    input  logic              done_valid,
    input  logic              done_err,
    output ctl_word_t         ctl_out
);
    logic             start_q, err_q, fin_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W:0]   sent_q, words;
    logic             f_empty, f_full, take, finish;

    assign words    = ({1'b0, len_q} + (LEN_W+1)'(3)) >> 2;
    assign out_valid = start_q && !f_empty && (sent_q != words);
    assign out_last  = (sent_q + 1'b1 == words);
    assign take      = out_valid && out_ready;
    assign finish    = done_valid && start_q;

    pktbuf_word_fifo #(.W(BUS_DW), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .flush(finish),
        .wr(host_wr && !start_q), .wdata(host_wdata),
        .rd(take), .rdata(out_data),
        .empty(f_empty), .full(f_full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= 1'b0;
            err_q   <= 1'b0;
            fin_q   <= 1'b0;
            len_q   <= '0;
            sent_q  <= '0;
        end else if (start_q) begin
            if (take) sent_q <= sent_q + 1'b1;
            if (finish) begin
                start_q <= 1'b0;
                err_q   <= done_err;
                fin_q   <= 1'b1;
            end
        end else if (ctl_wr) begin
            err_q <= 1'b0;
            fin_q <= 1'b0;
            if (ctl_start) begin
                start_q <= 1'b1;
                len_q   <= ctl_len;
                sent_q  <= '0;
            end
        end
    end

    always_comb begin
        ctl_out                = '0;
        ctl_out.own            = start_q;
        ctl_out.err            = err_q;
        ctl_out.aux            = fin_q;
        ctl_out.len[LEN_W-1:0] = len_q;
    end
endmodule

// File: rtl/pktbuf_host_if.sv
module pktbuf_host_if
    import pktbuf_pkg::*;
#(
    parameter int MAX_FRAME = 1518,
    parameter int LEN_W     = $clog2(MAX_FRAME + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    input  logic              rx_push_valid,
    input  logic [BUS_DW-1:0] rx_push_data,
    input  logic              rx_push_last,
    input  logic [LEN_W-1:0]  rx_push_len,
    input  logic              rx_push_err,
    input  logic              rx_push_crc,
    output logic              rx_push_ready,
    output logic              tx_pop_valid,
    output logic [BUS_DW-1:0] tx_pop_data,
    output logic              tx_pop_last,
    input  logic              tx_pop_ready,
    input  logic              tx_done_valid,
    input  logic              tx_done_err,
    output logic              irq
);
    localparam int DEPTH = (MAX_FRAME + 3) / 4;

    reg_sel_e          sel;
    ctl_word_t         rx_ctl_w, tx_ctl_w, wr_ctl;
    logic [BUS_DW-1:0] rx_word;
    logic [1:0]        irq_en_q;

    assign sel    = reg_sel_e'(bus_addr);
    assign wr_ctl = ctl_word_t'(bus_wdata[$bits(ctl_word_t)-1:0]);

    pktbuf_rx_side #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_rx (
        .clk(clk), .rst(rst),
        .in_valid(rx_push_valid), .in_data(rx_push_data), .in_last(rx_push_last),
        .in_len(rx_push_len), .in_err(rx_push_err), .in_crc(rx_push_crc),
        .in_ready(rx_push_ready),
        .host_pop(bus_re && sel == SEL_RX_WORD),
        .host_ack(bus_we && sel == SEL_RX_CTL && bus_wdata == '0),
        .word_out(rx_word), .ctl_out(rx_ctl_w)
    );

    pktbuf_tx_side #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_tx (
        .clk(clk), .rst(rst),
        .host_wr(bus_we && sel == SEL_TX_WORD), .host_wdata(bus_wdata),
        .ctl_wr(bus_we && sel == SEL_TX_CTL), .ctl_start(wr_ctl.own),
        .ctl_len(wr_ctl.len[LEN_W-1:0]),
        .out_valid(tx_pop_valid), .out_data(tx_pop_data), .out_last(tx_pop_last),
        .out_ready(tx_pop_ready),
        .done_valid(tx_done_valid), .done_err(tx_done_err),
        .ctl_out(tx_ctl_w)
    );

    always_ff @(posedge clk) begin
        if (rst)                               irq_en_q <= '0;
        else if (bus_we && sel == SEL_IRQ_EN)  irq_en_q <= bus_wdata[1:0];
    end

    always_comb begin
        case (sel)
            SEL_RX_CTL:  bus_rdata = ctl_to_bus(rx_ctl_w);
            SEL_RX_WORD: bus_rdata = rx_word;
            SEL_TX_CTL:  bus_rdata = ctl_to_bus(tx_ctl_w);
            SEL_IRQ_EN:  bus_rdata = {{(BUS_DW-2){1'b0}}, irq_en_q};
            default:     bus_rdata = '0;
        endcase
    end

    assign irq = (irq_en_q[0] && rx_ctl_w.own) || (irq_en_q[1] && tx_ctl_w.aux);
endmodule

// File: rtl/pktbuf_host_if_chk.sv
module pktbuf_host_if_chk (
    input logic        clk,
    input logic        rst,
    input logic        bus_we,
    input logic        bus_re,
    input logic [2:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic        rx_push_ready,
    input logic        rx_rdy,
    input logic        tx_start,
    input logic        tx_fin,
    input logic        tx_pop_valid,
    input logic        tx_done_valid,
    input logic [1:0]  irq_en,
    input logic        irq
);
    p_held_frame_blocks_push_r5: assert property (@(posedge clk) disable iff (rst)
        rx_rdy |-> !rx_push_ready);

    p_idle_read_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_re && bus_addr == 3'd1 && !rx_rdy) |-> bus_rdata == 32'd0);

    p_ack_releases_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 3'd0 && bus_wdata == 32'd0 && rx_rdy) |=> !rx_rdy);

    p_done_clears_start_r7: assert property (@(posedge clk) disable iff (rst)
        (tx_done_valid && tx_start) |=> (!tx_start && tx_fin));

    p_masked_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (irq_en == 2'b00) |-> !irq);

    p_stream_needs_start_r6: assert property (@(posedge clk) disable iff (rst)
        tx_pop_valid |-> tx_start);
endmodule

bind pktbuf_host_if pktbuf_host_if_chk u_chk (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_push_ready(rx_push_ready), .rx_rdy(rx_ctl_w.own),
    .tx_start(tx_ctl_w.own), .tx_fin(tx_ctl_w.aux),
    .tx_pop_valid(tx_pop_valid), .tx_done_valid(tx_done_valid),
    .irq_en(irq_en_q), .irq(irq)
);

// File: tb/tb_pktbuf_host_if.sv
`timescale 1ns/1ps
module tb_pktbuf_host_if;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 0, bus_re = 0;
    logic [2:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic        rx_push_valid = 0, rx_push_last = 0, rx_push_err = 0, rx_push_crc = 0;
    logic [31:0] rx_push_data = 0;
    logic [10:0] rx_push_len = 0;
    logic        rx_push_ready;
    logic        tx_pop_valid, tx_pop_last;
    logic [31:0] tx_pop_data;
    logic        tx_pop_ready = 0, tx_done_valid = 0, tx_done_err = 0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    pktbuf_host_if dut (.*);

    localparam int NV = 4;
    localparam int V_LEN [NV] = '{64, 5, 8, 1518};
    localparam bit V_ERR [NV] = '{1'b0, 1'b1, 1'b0, 1'b0};
    localparam bit V_CRC [NV] = '{1'b0, 1'b0, 1'b1, 1'b0};

    function automatic logic [31:0] pat(input int f, input int k);
        return (32'(f) << 24) ^ (32'(k) * 32'h0001_0003) ^ 32'h0000_5A00;
    endfunction

    function automatic logic [31:0] rx_exp(input bit rdy, input bit e, input bit c, input int len);
        return {16'd0, rdy, e, c, 13'(len)};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1 bus_we = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk); bus_re = 1; bus_addr = a; #1 d = bus_rdata;
        @(posedge clk); #1 bus_re = 0;
    endtask

    task automatic push_frame(input int f, input int len, input bit e, input bit c);
        int nw = (len + 3) / 4;
        for (int k = 0; k < nw; k++) begin
            @(negedge clk);
            rx_push_valid = 1; rx_push_data = pat(f, k); rx_push_last = (k == nw - 1);
            rx_push_len = 11'(len); rx_push_err = e; rx_push_crc = c;
            @(posedge clk); #1 rx_push_valid = 0; rx_push_last = 0;
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        errors++; checks++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        logic [31:0] v;
        int bad;
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R11 / R5 reset state
        rd(3'd0, v); chk("R11 rx ctl after reset", v, 0);
        rd(3'd2, v); chk("R11 tx ctl after reset", v, 0);
        rd(3'd4, v); chk("R11 irq enable after reset", v, 0);
        @(negedge clk); #1;
        chk("R11 irq after reset", 32'(irq), 0);
        chk("R5 push ready after reset", 32'(rx_push_ready), 1);

        // receive table
        for (int i = 0; i < NV; i++) begin
            rd(3'd1, v); chk("R4 idle data read is zero", v, 0);
            push_frame(i, V_LEN[i], V_ERR[i], V_CRC[i]);
            rd(3'd0, v); chk("R1 R12 rx ctl after frame", v, rx_exp(1, V_ERR[i], V_CRC[i], V_LEN[i]));
            @(negedge clk); #1 chk("R5 push blocked while held", 32'(rx_push_ready), 0);
            bad = 0;
            for (int k = 0; k < (V_LEN[i] + 3) / 4; k++) begin
                rd(3'd1, v);
                if (v !== pat(i, k)) begin
                    bad++;
                    if (bad == 1) $display("FAIL R2 word %0d actual=%h expected=%h", k, v, pat(i, k));
                end
            end
            checks++; if (bad != 0) errors++;
            rd(3'd1, v); chk("R2 drained buffer reads zero", v, 0);
            if (i == 0) begin
                wr(3'd0, 32'h1);
                rd(3'd0, v); chk("R3 nonzero write ignored", v, rx_exp(1, 0, 0, 64));
            end
            wr(3'd0, 32'h0);
            rd(3'd0, v); chk("R3 ack clears ctl", v, 0);
            @(negedge clk); #1 chk("R3 push ready after ack", 32'(rx_push_ready), 1);
        end

        // R3 ack discards undrained words
        push_frame(7, 12, 0, 0);
        rd(3'd1, v); chk("R2 first word", v, pat(7, 0));
        wr(3'd0, 32'h0);
        push_frame(8, 4, 0, 0);
        rd(3'd1, v); chk("R3 leftover discarded", v, pat(8, 0));

        // R9 interrupt masking
        @(negedge clk); #1 chk("R9 irq masked with zero enable", 32'(irq), 0);
        wr(3'd4, 32'h1);
        @(negedge clk); #1 chk("R9 rx cause raises irq", 32'(irq), 1);
        wr(3'd4, 32'h0);
        @(negedge clk); #1 chk("R9 zero enable masks", 32'(irq), 0);
        wr(3'd0, 32'h0);

        // R6 normal transmission: 10 bytes, 3 words
        for (int k = 0; k < 3; k++) wr(3'd3, pat(20, k));
        wr(3'd2, 32'h0000_800A);
        rd(3'd2, v); chk("R6 start bit set", v, 32'h0000_800A);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); tx_pop_ready = 1; #1;
            chk("R6 tx valid", 32'(tx_pop_valid), 1);
            chk("R6 tx data", tx_pop_data, pat(20, k));
            chk("R6 tx last", 32'(tx_pop_last), 32'(k == 2));
            @(posedge clk); #1 tx_pop_ready = 0;
        end
        @(negedge clk); #1 chk("R6 stream stops", 32'(tx_pop_valid), 0);
        wr(3'd4, 32'h2);
        @(negedge clk); tx_done_valid = 1; tx_done_err = 0;
        @(posedge clk); #1 tx_done_valid = 0;
        rd(3'd2, v); chk("R7 done ok", v, 32'h0000_200A);
        @(negedge clk); #1 chk("R9 tx cause raises irq", 32'(irq), 1);
        wr(3'd2, 32'h0);
        rd(3'd2, v); chk("R10 ack clears done", v, 32'h0000_000A);
        @(negedge clk); #1 chk("R9 irq drops after tx ack", 32'(irq), 0);

        // R8 late write ignored: 8 bytes, only one word before start
        wr(3'd3, pat(30, 0));
        wr(3'd2, 32'h0000_8008);
        wr(3'd3, 32'hDEAD_BEEF);
        @(negedge clk); tx_pop_ready = 1; #1;
        chk("R8 first word", tx_pop_data, pat(30, 0));
        @(posedge clk); #1 tx_pop_ready = 0;
        @(negedge clk); #1 chk("R8 late word not stored", 32'(tx_pop_valid), 0);
        @(negedge clk); tx_done_valid = 1; tx_done_err = 1;
        @(posedge clk); #1 tx_done_valid = 0; tx_done_err = 0;
        rd(3'd2, v); chk("R7 failure recorded", v, 32'h0000_6008);
        wr(3'd2, 32'h0);
        rd(3'd2, v); chk("R10 ack clears error", v, 32'h0000_0008);

        summary();
    end
endmodule